// File: doc/BRIEF.md
# USB High-Speed Mode Detection Controller

This block follows the connection state of one USB 2.0 link and drives the status outputs of a signal conditioner. It does not sense analog levels. It works from pre-decoded line conditions: a pull-up has been sensed, a detach has been sensed, J, K, SE0, squelch, a compliance test fixture is present, and a test packet has been observed. It also takes a single-cycle tick once every microsecond.

When a pull-up appears on an unattached link, the controller reports an attachment. From then on it waits for a bus reset, which is an SE0 that lasts long enough to count as one. After the reset it times exactly one chirp J followed directly by one chirp K. When squelch then appears, it raises the high-speed indication and turns on compensation. Low-speed and full-speed links, and any handshake that fails, keep compensation off but remain reported as attached. There is a second way into high speed that is used only for compliance testing: a test fixture is detected on an unattached link and a test packet is then seen.

Top module: `usbhs_mode_det`

## Requirements
- R1: When `pullup_det` is high in the unattached state and `fixture_det` is low, `conn_flag` rises one clock later. In the unattached state, `conn_flag` stays low.
- R2: The following sequence sets `hs_flag` and `comp_en` one clock after the squelch cycle. First, an SE0 lasting at least `SE0_RESET_US` ticks while attached. Then one chirp J, followed directly by one chirp K, each lasting between 18 and 128 ticks inclusive. Then `squelch`.
- R3: A chirp is measured in ticks of `tick_us`, not in clock cycles. If either chirp lasts fewer than 18 ticks or more than 128 ticks, the handshake is abandoned. The link then stays attached at full speed (`conn_flag`=1, `hs_flag`=0), and `squelch` is ignored until the next long SE0.
- R4: A further chirp J seen after a valid K and before squelch abandons the handshake, in the same way as R3.
- R5: In the unattached state, `fixture_det` takes priority over `pullup_det`. A later `test_pkt_seen` sets `hs_flag` and `comp_en` one clock later while `conn_flag` stays 0.
- R6: `comp_en` is high only while `hs_flag` is high. It stays 0 on low-speed and full-speed links.
- R7: `disconnect_det` clears all three outputs one clock later and returns the controller to the unattached state. This applies in any state and overrides any other event in the same cycle.
- R8: A long SE0 while in high speed clears `hs_flag` and `comp_en`, keeps `conn_flag`, and re-arms handshake detection.
- R9: While `rst_n` is low, all three outputs are 0.
- R10: While `cfg_hold` is 1, the controller stays unattached and idle, with all outputs 0 one clock later. After `cfg_hold` is released, tracking resumes from the unattached state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hold | input | 1 | Configuration active: controller idles |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| pullup_det | input | 1 | Pull-up on D+ or D- sensed |
| disconnect_det | input | 1 | Device detach sensed |
| line_j | input | 1 | Line in J state |
| line_k | input | 1 | Line in K state |
| line_se0 | input | 1 | Line in SE0 state |
| squelch | input | 1 | Squelch detected |
| fixture_det | input | 1 | Compliance test fixture sensed |
| test_pkt_seen | input | 1 | Test packet pattern observed |
| conn_flag | output | 1 | Device attached |
| hs_flag | output | 1 | Link in high-speed mode |
| comp_en | output | 1 | Signal compensation enable |

## Verification
Two events can arrive in the same cycle. The squelch that completes a valid handshake can coincide with a detach. Separately, on an unattached link, a fixture can be sensed together with a pull-up. The bench drives the controller into the squelch-wait state and then raises squelch and detach together for a single cycle. All outputs must read 0 afterwards, with no high-speed pulse. It also raises fixture and pull-up in the same cycle and expects `conn_flag` to stay low. The handshake must then complete only through a test packet.

// File: rtl/usbhs_det_pkg.sv
package usbhs_det_pkg;

    typedef enum logic [2:0] {
        ST_UNATT   = 3'd0,
        ST_ATTACH  = 3'd1,
        ST_BUSRST  = 3'd2,
        ST_CHIRP_J = 3'd3,
        ST_CHIRP_K = 3'd4,
        ST_WAIT_SQ = 3'd5,
        ST_HIGH    = 3'd6,
        ST_FIXTURE = 3'd7
    } hsd_state_e;

    typedef struct packed {
        hsd_state_e state;
        logic       conn;
        logic       hs;
        logic       comp;
    } hsd_ctrl_t;

endpackage

// File: rtl/usbhs_se0_timer.sv
module usbhs_se0_timer #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se0,
    input  logic tick,
    output logic long_se0
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_C = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!se0) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LIM_C)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign long_se0 = (cnt_q == LIM_C);

    AST_SE0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !se0 |=> !long_se0); // R8

endmodule

// File: rtl/usbhs_chirp_timer.sv
module usbhs_chirp_timer #(
    parameter int MIN_TICKS = 18,
    parameter int MAX_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic in_window,
    output logic overrun
);
    localparam int SAT = MAX_TICKS + 1;
    localparam int W   = $clog2(SAT + 1);
    localparam logic [W-1:0] MIN_C = W'(MIN_TICKS);
    localparam logic [W-1:0] MAX_C = W'(MAX_TICKS);
    localparam logic [W-1:0] SAT_C = W'(SAT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = inc ? W'(1) : '0;
        end else if (inc && (cnt_q != SAT_C)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign in_window = (cnt_q >= MIN_C) && (cnt_q <= MAX_C);
    assign overrun   = (cnt_q > MAX_C);

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (cnt_q >= $past(cnt_q))); // R3

endmodule

// File: rtl/usbhs_mode_det.sv
module usbhs_mode_det
    import usbhs_det_pkg::*;
#(
    parameter int SE0_RESET_US = 2500,
    parameter int CHIRP_MIN_US = 18,
    parameter int CHIRP_MAX_US = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_hold,
    input  logic tick_us,
    input  logic pullup_det,
    input  logic disconnect_det,
    input  logic line_j,
    input  logic line_k,
    input  logic line_se0,
    input  logic squelch,
    input  logic fixture_det,
    input  logic test_pkt_seen,
    output logic conn_flag,
    output logic hs_flag,
    output logic comp_en
);

    hsd_ctrl_t ctl_d, ctl_q;
    logic      long_se0;
    logic      tmr_clr, tmr_inc;
    logic      tmr_in_win, tmr_over;

    usbhs_se0_timer #(
        .LIMIT(SE0_RESET_US)
    ) u_se0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .se0     (line_se0),
        .tick    (tick_us),
        .long_se0(long_se0)
    );

    usbhs_chirp_timer #(
        .MIN_TICKS(CHIRP_MIN_US),
        .MAX_TICKS(CHIRP_MAX_US)
    ) u_chirp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .inc      (tmr_inc),
        .in_window(tmr_in_win),
        .overrun  (tmr_over)
    );

    always_comb begin
        ctl_d   = ctl_q;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;

        case (ctl_q.state)
            ST_UNATT: begin
                if (fixture_det) begin
                    ctl_d.state = ST_FIXTURE;
                end else if (pullup_det) begin
                    ctl_d.state = ST_ATTACH;
                    ctl_d.conn  = 1'b1;
                end
            end
            ST_ATTACH: begin
                if (long_se0) ctl_d.state = ST_BUSRST;
            end
            ST_BUSRST: begin
                if (line_j) begin
                    ctl_d.state = ST_CHIRP_J;
                    tmr_clr     = 1'b1;
                    tmr_inc     = tick_us;
                end
            end
            ST_CHIRP_J: begin
                if (line_j) begin
                    tmr_inc = tick_us;
                    if (tmr_over) ctl_d.state = ST_ATTACH;
                end else if (line_k && tmr_in_win) begin
                    ctl_d.state = ST_CHIRP_K;
                    tmr_clr     = 1'b1;
                    tmr_inc     = tick_us;
                end else begin
                    ctl_d.state = ST_ATTACH;
                end
            end
            ST_CHIRP_K: begin
                if (line_k) begin
                    tmr_inc = tick_us;
                    if (tmr_over) ctl_d.state = ST_ATTACH;
                end else if (tmr_in_win) begin
                    ctl_d.state = ST_WAIT_SQ;
                end else begin
                    ctl_d.state = ST_ATTACH;
                end
            end
            ST_WAIT_SQ: begin
                if (line_j) begin
                    ctl_d.state = ST_ATTACH;
                end else if (squelch) begin
                    ctl_d.state = ST_HIGH;
                end else if (long_se0) begin
                    ctl_d.state = ST_BUSRST;
                end
            end
            ST_HIGH: begin
                if (long_se0) ctl_d.state = ST_BUSRST;
            end
            ST_FIXTURE: begin
                if (test_pkt_seen) ctl_d.state = ST_HIGH;
            end
            default: begin
                ctl_d.state = ST_UNATT;
            end
        endcase

        if (disconnect_det || cfg_hold) begin
            ctl_d.state = ST_UNATT;
            tmr_clr     = 1'b1;
            tmr_inc     = 1'b0;
        end

        if (ctl_d.state == ST_UNATT || ctl_d.state == ST_FIXTURE) begin
            ctl_d.conn = 1'b0;
        end
        ctl_d.hs   = (ctl_d.state == ST_HIGH);
        ctl_d.comp = ctl_d.hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_UNATT;
            ctl_q.conn  <= 1'b0;
            ctl_q.hs    <= 1'b0;
            ctl_q.comp  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign conn_flag = ctl_q.conn;
    assign hs_flag   = ctl_q.hs;
    assign comp_en   = ctl_q.comp;

    AST_CONN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conn_flag) |-> $past(pullup_det)); // R1

    AST_HS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_flag) |-> ($past(squelch) || $past(test_pkt_seen))); // R2

    AST_DISCON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect_det |=> (!conn_flag && !hs_flag && !comp_en)); // R7

    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> (!conn_flag && !hs_flag && !comp_en)); // R10

    AST_HS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_flag) |-> ($past(disconnect_det) || $past(cfg_hold) || $past(long_se0))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!conn_flag && !hs_flag && !comp_en)); // R9

endmodule

// File: tb/sim_usbhs_mode_det.sv
module sim_usbhs_mode_det;

    localparam int CLK_PERIOD = 10;
    localparam int SE0_LIM    = 40;

    typedef struct packed {
        logic [7:0] stim;   // {pkt, fix, sq, se0, k, j, dc, pu}
        logic [7:0] cyc;
        logic [2:0] expv;   // {conn, hs, comp}
        logic [3:0] req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t TBL [NV] = '{
        '{8'b00000000, 8'd3,   3'b000, 4'd1},  // R1 idle unattached
        '{8'b00000001, 8'd2,   3'b100, 4'd1},  // R1 attach
        '{8'b00010001, 8'd45,  3'b100, 4'd2},  // R2 bus reset
        '{8'b00000101, 8'd20,  3'b100, 4'd2},  // R2 chirp J
        '{8'b00001001, 8'd20,  3'b100, 4'd2},  // R2 chirp K
        '{8'b00000001, 8'd3,   3'b100, 4'd2},  // R2 waiting squelch
        '{8'b00100001, 8'd2,   3'b111, 4'd2},  // R2 high speed
        '{8'b00000001, 8'd3,   3'b111, 4'd2},  // R2 holds
        '{8'b00010001, 8'd45,  3'b100, 4'd8},  // R8 re-reset clears hs
        '{8'b00000101, 8'd10,  3'b100, 4'd3},  // R3 short J
        '{8'b00001001, 8'd20,  3'b100, 4'd3},
        '{8'b00100001, 8'd3,   3'b100, 4'd6},  // R6 full speed, comp off
        '{8'b00010001, 8'd45,  3'b100, 4'd3},
        '{8'b00000101, 8'd128, 3'b100, 4'd3},  // R3 J at max
        '{8'b00001001, 8'd18,  3'b100, 4'd3},  // R3 K at min
        '{8'b00100001, 8'd2,   3'b111, 4'd3},  // R3 boundary accepted
        '{8'b00010001, 8'd45,  3'b100, 4'd8},
        '{8'b00000101, 8'd129, 3'b100, 4'd3},  // R3 J too long
        '{8'b00001001, 8'd20,  3'b100, 4'd3},
        '{8'b00100001, 8'd2,   3'b100, 4'd3},
        '{8'b00010001, 8'd45,  3'b100, 4'd3},
        '{8'b00000101, 8'd18,  3'b100, 4'd3},
        '{8'b00001001, 8'd17,  3'b100, 4'd3},  // R3 K too short
        '{8'b00100001, 8'd2,   3'b100, 4'd3},
        '{8'b00010001, 8'd45,  3'b100, 4'd4},
        '{8'b00000101, 8'd20,  3'b100, 4'd4},
        '{8'b00001001, 8'd20,  3'b100, 4'd4},
        '{8'b00000101, 8'd20,  3'b100, 4'd4},  // R4 second J
        '{8'b00100001, 8'd2,   3'b100, 4'd4},
        '{8'b00010001, 8'd45,  3'b100, 4'd7},
        '{8'b00000101, 8'd20,  3'b100, 4'd7},
        '{8'b00001001, 8'd20,  3'b100, 4'd7},
        '{8'b00000001, 8'd2,   3'b100, 4'd7},  // waiting squelch
        '{8'b00100010, 8'd1,   3'b000, 4'd7},  // R7 squelch and detach together
        '{8'b00000000, 8'd2,   3'b000, 4'd7},
        '{8'b01000001, 8'd1,   3'b000, 4'd5},  // R5 fixture beats pull-up
        '{8'b00000000, 8'd2,   3'b000, 4'd5},
        '{8'b10000000, 8'd1,   3'b011, 4'd5},  // R5 test packet
        '{8'b00000000, 8'd2,   3'b011, 4'd5},
        '{8'b00000010, 8'd1,   3'b000, 4'd7},  // R7 detach from high speed
        '{8'b00000001, 8'd2,   3'b100, 4'd1},
        '{8'b00000010, 8'd1,   3'b000, 4'd7}   // R7 detach while attached
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hold = 1'b0, tick_us = 1'b0;
    logic pullup_det = 1'b0, disconnect_det = 1'b0;
    logic line_j = 1'b0, line_k = 1'b0, line_se0 = 1'b0, squelch = 1'b0;
    logic fixture_det = 1'b0, test_pkt_seen = 1'b0;
    logic conn_flag, hs_flag, comp_en;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usbhs_mode_det #(
        .SE0_RESET_US(SE0_LIM),
        .CHIRP_MIN_US(18),
        .CHIRP_MAX_US(128)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .tick_us(tick_us),
        .pullup_det(pullup_det), .disconnect_det(disconnect_det),
        .line_j(line_j), .line_k(line_k), .line_se0(line_se0),
        .squelch(squelch), .fixture_det(fixture_det),
        .test_pkt_seen(test_pkt_seen),
        .conn_flag(conn_flag), .hs_flag(hs_flag), .comp_en(comp_en)
    );

    task automatic check(input string tag, input logic [2:0] expv);
        n_checks++;
        if ({conn_flag, hs_flag, comp_en} !== expv) begin
            n_errors++;
            $display("FAIL %s: conn/hs/comp got %b expected %b", tag,
                     {conn_flag, hs_flag, comp_en}, expv);
        end
    endtask

    task automatic run_vec(input logic [7:0] v, input int n, input bit half_tick);
        {test_pkt_seen, fixture_det, squelch, line_se0,
         line_k, line_j, disconnect_det, pullup_det} = v;
        for (int c = 0; c < n; c++) begin
            tick_us = half_tick ? c[0] : 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL R0 watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 outputs during reset", 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset release", 3'b000);

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i].stim, int'(TBL[i].cyc), 1'b0);
            check($sformatf("R%0d table row %0d", TBL[i].req, i), TBL[i].expv);
        end

        // R3: chirp length counts ticks, 30 cycles at half rate = 15 ticks
        run_vec(8'b00000001, 2, 1'b0);
        run_vec(8'b00010001, 45, 1'b0);
        run_vec(8'b00000101, 30, 1'b1);
        run_vec(8'b00001001, 20, 1'b0);
        run_vec(8'b00100001, 2, 1'b0);
        check("R3 half-rate short J rejected", 3'b100);

        // R3: 40 cycles at half rate = 20 ticks, accepted
        run_vec(8'b00010001, 45, 1'b0);
        run_vec(8'b00000101, 40, 1'b1);
        run_vec(8'b00001001, 20, 1'b0);
        run_vec(8'b00100001, 2, 1'b0);
        check("R3 half-rate J accepted", 3'b111);

        // R9: reset while in high speed
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset in high speed", 3'b000);
        run_vec(8'b00000000, 1, 1'b0);
        rst_n = 1'b1;
        run_vec(8'b00000000, 2, 1'b0);
        check("R9 idle after reset", 3'b000);

        // R10: configuration hold blocks attach and fixture
        cfg_hold = 1'b1;
        run_vec(8'b00000001, 3, 1'b0);
        check("R10 pull-up ignored in hold", 3'b000);
        run_vec(8'b11000000, 3, 1'b0);
        check("R10 fixture ignored in hold", 3'b000);
        cfg_hold = 1'b0;
        run_vec(8'b00000001, 1, 1'b0);
        check("R10 resumes after hold", 3'b100);
        cfg_hold = 1'b1;
        run_vec(8'b00000001, 1, 1'b0);
        check("R10 hold clears attach", 3'b000);
        cfg_hold = 1'b0;

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule